// File: doc/BRIEF.md
# Audio Transmit Sample Buffer with Burst DMA Request

This block holds the audio samples that wait to go out to the serial audio transmitter. Software or a DMA engine pushes words through a write-only data port. Each word is aligned into a sample according to a one-bit alignment mode, and is then queued in a 64-entry first-in first-out store. The serializer takes samples from the head of the queue over a valid/ready stream. A 32-bit counter records every sample that the serializer consumes. Software can load this counter, which is how it is set back to zero.

A DMA request line tells the DMA engine when there is room for one full burst of four words. The request is gated by a DMA enable control. A flush control empties the queue in two steps. The flush is busy for one cycle, and the queue reports empty on the cycle after that. The bus side is reduced to plain write strobes, and each strobe carries its own data.

Back-pressure rules on the outgoing stream: `smp_valid` is never high while the queue is empty or a flush is busy. Once `smp_valid` is raised, it stays high and `smp_data` stays unchanged until `smp_ready` completes the transfer, unless a flush is requested. The write side has no back-pressure. A word written while the queue is full is discarded and latches the overflow flag.

Top module: `audio_tx_fifo`

## Requirements
- R1: Samples leave in the order they were written. `smp_valid` is low while the queue is empty. While `smp_valid` is high and `smp_ready` is low, with no flush requested, `smp_valid` stays high and `smp_data` is unchanged on the next cycle.
- R2: Reads of the data port (`data_rdata`) always return zero, whatever the queue holds.
- R3: The queue holds 64 entries. A data write while `fifo_full` is high is dropped, and `level` stays at 64. The drop sets `overflow`, which stays set (including across a flush) until reset.
- R4: A pulse on `fctl_flush` makes `flush_busy` high for exactly the next cycle. `smp_valid` is low during that cycle. On the cycle after, `fifo_empty` is 1 and `level` is 0. A data write made during the busy cycle is discarded and does not set `overflow`.
- R5: The alignment mode is loaded from `fctl_mode` on each `fctl_we`. It applies at write time. Mode 0 stores the written word unchanged. Mode 1 places the low 16 bits of the word in the upper half of the sample and zeros the lower half. For example, 0xAAAA1234 becomes 0x12340000.
- R6: `tx_count` increments by one on every cycle where `smp_valid` and `smp_ready` are both high.
- R7: A `cnt_we` strobe loads `cnt_wdata` into `tx_count` on the next edge. The load takes priority over an increment in the same cycle.
- R8: `tx_count` wraps from 0xFFFFFFFF to 0 and does not saturate.
- R9: `dma_req` is high exactly when the DMA enable is set and at least 4 entries are free (`level` no more than 60). The DMA enable is loaded from `dctl_dma_en` on each `dctl_we`.
- R10: After reset, the queue is empty, `smp_valid`, `dma_req`, `overflow` and `flush_busy` are 0, `tx_count` is 0, and the alignment mode is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| data_we | input | 1 | Write strobe for the data port |
| data_wdata | input | 32 | Word pushed into the queue |
| data_rdata | output | 32 | Read value of the data port, always zero |
| fctl_we | input | 1 | Write strobe for the FIFO control fields |
| fctl_flush | input | 1 | Flush request, sampled with `fctl_we` |
| fctl_mode | input | 1 | Alignment mode, loaded with `fctl_we` |
| dctl_we | input | 1 | Write strobe for the DMA control field |
| dctl_dma_en | input | 1 | DMA request enable, loaded with `dctl_we` |
| cnt_we | input | 1 | Write strobe for the consumed-sample counter |
| cnt_wdata | input | 32 | Value loaded into the counter |
| smp_valid | output | 1 | A sample is offered to the serializer |
| smp_ready | input | 1 | The serializer accepts the offered sample |
| smp_data | output | 32 | Sample at the head of the queue |
| tx_count | output | 32 | Consumed-sample counter |
| dma_req | output | 1 | Room for one DMA burst |
| level | output | 7 | Number of queued entries |
| fifo_empty | output | 1 | Queue holds nothing |
| fifo_full | output | 1 | Queue holds 64 entries |
| flush_busy | output | 1 | Flush is in progress this cycle |
| overflow | output | 1 | Sticky flag for dropped writes |

## Verification
The bench drives the queue from empty to full. A design that miscounts the burst threshold would raise `dma_req` at 61 entries or drop it at 60. A design that accepts a 65th word would corrupt the head sample or wrap `level`. The bench also checks the flush in its two steps and writes data during the busy cycle. A flush that clears too early, or that lets that write land, would leave `level` non-zero.

On the counter, the bench checks the wrap from all ones to zero and a load that coincides with a consumed sample. A saturating counter, or one where the increment wins over the load, gives a wrong `tx_count`. Held back-pressure and mode 1 alignment are also checked. A design that let the head sample change while waiting, or that shifted the half-word the wrong way, would present the wrong `smp_data`.

// File: rtl/atxf_pkg.sv
package atxf_pkg;
  typedef enum logic {
    ALIGN_WORD    = 1'b0,
    ALIGN_HALF_HI = 1'b1
  } align_mode_e;
endpackage

// File: rtl/atxf_align.sv
module atxf_align
  import atxf_pkg::*;
#(
  parameter int SAMPLE_W = 32
) (
  input  align_mode_e         mode,
  input  logic [SAMPLE_W-1:0] din,
  output logic [SAMPLE_W-1:0] dout
);
  localparam int HALF_W = SAMPLE_W / 2;

  always_comb begin
    unique case (mode)
      ALIGN_HALF_HI: dout = {din[HALF_W-1:0], {(SAMPLE_W-HALF_W){1'b0}}};
      default:       dout = din;
    endcase
  end
endmodule

// File: rtl/atxf_store.sv
module atxf_store #(
  parameter int SAMPLE_W = 32,
  parameter int DEPTH    = 64,
  localparam int AW      = $clog2(DEPTH),
  localparam int LVL_W   = AW + 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clear,
  input  logic                push,
  input  logic [SAMPLE_W-1:0] din,
  input  logic                pop,
  output logic [SAMPLE_W-1:0] dout,
  output logic [LVL_W-1:0]    level,
  output logic                full,
  output logic                empty
);
  logic [SAMPLE_W-1:0] mem [DEPTH];
  logic [AW-1:0]       wr_ptr, rd_ptr;

  always_ff @(posedge clk) begin
    if (push && !clear) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else if (clear) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else begin
      if (push) wr_ptr <= wr_ptr + AW'(1);
      if (pop)  rd_ptr <= rd_ptr + AW'(1);
      unique case ({push, pop})
        2'b10:   level <= level + LVL_W'(1);
        2'b01:   level <= level - LVL_W'(1);
        default: level <= level;
      endcase
    end
  end

  assign dout  = mem[rd_ptr];
  assign empty = (level == '0);
  assign full  = (level == LVL_W'(DEPTH));
endmodule

// File: rtl/atxf_counter.sv
module atxf_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             inc,
  output logic [CNT_W-1:0] value
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    value <= '0;
    else if (load) value <= load_val;
    else if (inc)  value <= value + CNT_W'(1);
  end
endmodule

// File: rtl/audio_tx_fifo.sv
module audio_tx_fifo
  import atxf_pkg::*;
#(
  parameter int SAMPLE_W = 32,
  parameter int DEPTH    = 64,
  parameter int BURST    = 4,
  parameter int CNT_W    = 32,
  localparam int LVL_W   = $clog2(DEPTH) + 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                data_we,
  input  logic [SAMPLE_W-1:0] data_wdata,
  output logic [SAMPLE_W-1:0] data_rdata,
  input  logic                fctl_we,
  input  logic                fctl_flush,
  input  logic                fctl_mode,
  input  logic                dctl_we,
  input  logic                dctl_dma_en,
  input  logic                cnt_we,
  input  logic [CNT_W-1:0]    cnt_wdata,
  output logic                smp_valid,
  input  logic                smp_ready,
  output logic [SAMPLE_W-1:0] smp_data,
  output logic [CNT_W-1:0]    tx_count,
  output logic                dma_req,
  output logic [LVL_W-1:0]    level,
  output logic                fifo_empty,
  output logic                fifo_full,
  output logic                flush_busy,
  output logic                overflow
);
  localparam logic [LVL_W-1:0] REQ_MAX_LVL = LVL_W'(DEPTH - BURST);

  align_mode_e         mode_q;
  logic                dma_en_q;
  logic                flush_q;
  logic                ovf_q;
  logic                push, pop;
  logic [SAMPLE_W-1:0] aligned;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q   <= ALIGN_WORD;
      dma_en_q <= 1'b0;
      flush_q  <= 1'b0;
      ovf_q    <= 1'b0;
    end else begin
      flush_q <= fctl_we && fctl_flush;
      if (fctl_we) mode_q <= align_mode_e'(fctl_mode);
      if (dctl_we) dma_en_q <= dctl_dma_en;
      if (data_we && fifo_full && !flush_q) ovf_q <= 1'b1;
    end
  end

  atxf_align #(.SAMPLE_W(SAMPLE_W)) u_align (
    .mode (mode_q),
    .din  (data_wdata),
    .dout (aligned)
  );

  assign push = data_we && !fifo_full && !flush_q;
  assign pop  = smp_valid && smp_ready;

  atxf_store #(.SAMPLE_W(SAMPLE_W), .DEPTH(DEPTH)) u_store (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (flush_q),
    .push  (push),
    .din   (aligned),
    .pop   (pop),
    .dout  (smp_data),
    .level (level),
    .full  (fifo_full),
    .empty (fifo_empty)
  );

  atxf_counter #(.CNT_W(CNT_W)) u_count (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (cnt_we),
    .load_val (cnt_wdata),
    .inc      (pop),
    .value    (tx_count)
  );

  assign smp_valid  = !fifo_empty && !flush_q;
  assign dma_req    = dma_en_q && (level <= REQ_MAX_LVL);
  assign flush_busy = flush_q;
  assign overflow   = ovf_q;
  assign data_rdata = '0;
endmodule

// File: rtl/audio_tx_fifo_checker.sv
module audio_tx_fifo_checker #(
  parameter int SAMPLE_W = 32,
  parameter int DEPTH    = 64,
  parameter int BURST    = 4,
  parameter int CNT_W    = 32,
  localparam int LVL_W   = $clog2(DEPTH) + 1
) (
  input logic                clk,
  input logic                rst_n,
  input logic                data_we,
  input logic                fctl_we,
  input logic                fctl_flush,
  input logic                cnt_we,
  input logic [CNT_W-1:0]    cnt_wdata,
  input logic                smp_valid,
  input logic                smp_ready,
  input logic [SAMPLE_W-1:0] smp_data,
  input logic [CNT_W-1:0]    tx_count,
  input logic                dma_req,
  input logic [LVL_W-1:0]    level,
  input logic                fifo_empty,
  input logic                fifo_full,
  input logic                flush_busy,
  input logic                overflow
);
  p_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    smp_valid && !smp_ready && !(fctl_we && fctl_flush)
    |=> smp_valid && $stable(smp_data));

  p_empty_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_empty |-> !smp_valid);

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    data_we && fifo_full && !flush_busy |=> overflow && fifo_full);

  p_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow);

  p_flush_r4: assert property (@(posedge clk) disable iff (!rst_n)
    flush_busy |=> fifo_empty && !flush_busy);

  p_count_inc_r6: assert property (@(posedge clk) disable iff (!rst_n)
    smp_valid && smp_ready && !cnt_we |=> tx_count == $past(tx_count) + CNT_W'(1));

  p_count_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_we |=> tx_count == $past(cnt_wdata));

  p_dma_room_r9: assert property (@(posedge clk) disable iff (!rst_n)
    dma_req |-> level <= LVL_W'(DEPTH - BURST));
endmodule

bind audio_tx_fifo audio_tx_fifo_checker #(
  .SAMPLE_W(SAMPLE_W), .DEPTH(DEPTH), .BURST(BURST), .CNT_W(CNT_W)
) u_checker (
  .clk(clk), .rst_n(rst_n), .data_we(data_we), .fctl_we(fctl_we),
  .fctl_flush(fctl_flush), .cnt_we(cnt_we), .cnt_wdata(cnt_wdata),
  .smp_valid(smp_valid), .smp_ready(smp_ready), .smp_data(smp_data),
  .tx_count(tx_count), .dma_req(dma_req), .level(level),
  .fifo_empty(fifo_empty), .fifo_full(fifo_full),
  .flush_busy(flush_busy), .overflow(overflow)
);

// File: tb/tb_audio_tx_fifo.sv
`timescale 1ns/1ps
module tb_audio_tx_fifo;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        data_we = 1'b0;
  logic [31:0] data_wdata = '0;
  logic [31:0] data_rdata;
  logic        fctl_we = 1'b0, fctl_flush = 1'b0, fctl_mode = 1'b0;
  logic        dctl_we = 1'b0, dctl_dma_en = 1'b0;
  logic        cnt_we = 1'b0;
  logic [31:0] cnt_wdata = '0;
  logic        smp_valid, smp_ready = 1'b0;
  logic [31:0] smp_data, tx_count;
  logic        dma_req, fifo_empty, fifo_full, flush_busy, overflow;
  logic [6:0]  level;

  int n_tests = 0, n_fail = 0;
  logic [31:0] exp_cnt = '0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  audio_tx_fifo dut (
    .clk(clk), .rst_n(rst_n), .data_we(data_we), .data_wdata(data_wdata),
    .data_rdata(data_rdata), .fctl_we(fctl_we), .fctl_flush(fctl_flush),
    .fctl_mode(fctl_mode), .dctl_we(dctl_we), .dctl_dma_en(dctl_dma_en),
    .cnt_we(cnt_we), .cnt_wdata(cnt_wdata), .smp_valid(smp_valid),
    .smp_ready(smp_ready), .smp_data(smp_data), .tx_count(tx_count),
    .dma_req(dma_req), .level(level), .fifo_empty(fifo_empty),
    .fifo_full(fifo_full), .flush_busy(flush_busy), .overflow(overflow)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [31:0] d);
    data_we = 1'b1; data_wdata = d;
    tick();
    data_we = 1'b0;
  endtask

  task automatic pop_expect(input logic [31:0] d, input string req);
    chk(smp_valid === 1'b1, req, 32'(smp_valid), 32'd1);
    chk(smp_data === d, req, smp_data, d);
    smp_ready = 1'b1;
    tick();
    smp_ready = 1'b0;
    exp_cnt = exp_cnt + 32'd1;
  endtask

  task automatic t_reset;
    chk(fifo_empty === 1'b1, "R10", 32'(fifo_empty), 1);
    chk(smp_valid === 1'b0, "R10", 32'(smp_valid), 0);
    chk(tx_count === 32'd0, "R10", tx_count, 0);
    chk(dma_req === 1'b0, "R10", 32'(dma_req), 0);
    chk(overflow === 1'b0 && flush_busy === 1'b0, "R10", 32'({overflow, flush_busy}), 0);
    chk(level === 7'd0, "R10", 32'(level), 0);
  endtask

  task automatic t_order;
    wr(32'h1111_0001); wr(32'h2222_0002); wr(32'h3333_0003);
    chk(level === 7'd3, "R1", 32'(level), 3);
    pop_expect(32'h1111_0001, "R1");
    pop_expect(32'h2222_0002, "R1");
    pop_expect(32'h3333_0003, "R1");
    chk(tx_count === exp_cnt, "R6", tx_count, exp_cnt);
    chk(smp_valid === 1'b0, "R1", 32'(smp_valid), 0);
  endtask

  task automatic t_backpressure;
    wr(32'hDDDD_0004); wr(32'hEEEE_0005);
    for (int i = 0; i < 3; i++) begin
      tick();
      chk(smp_valid === 1'b1 && smp_data === 32'hDDDD_0004, "R1", smp_data, 32'hDDDD_0004);
    end
    chk(tx_count === exp_cnt, "R6", tx_count, exp_cnt);
    pop_expect(32'hDDDD_0004, "R1");
    pop_expect(32'hEEEE_0005, "R1");
    chk(tx_count === exp_cnt, "R6", tx_count, exp_cnt);
  endtask

  task automatic t_mode;
    fctl_we = 1'b1; fctl_mode = 1'b1;
    tick();
    fctl_we = 1'b0;
    wr(32'hAAAA_1234);
    fctl_we = 1'b1; fctl_mode = 1'b0;
    tick();
    fctl_we = 1'b0;
    wr(32'h5678_ABCD);
    pop_expect(32'h1234_0000, "R5");
    pop_expect(32'h5678_ABCD, "R5");
  endtask

  task automatic t_rdzero;
    wr(32'hF0F0_F0F0);
    chk(data_rdata === 32'd0, "R2", data_rdata, 0);
    pop_expect(32'hF0F0_F0F0, "R2");
    chk(data_rdata === 32'd0, "R2", data_rdata, 0);
  endtask

  task automatic t_dma_full;
    dctl_we = 1'b1; dctl_dma_en = 1'b1;
    tick();
    dctl_we = 1'b0;
    chk(dma_req === 1'b1, "R9", 32'(dma_req), 1);
    for (int i = 0; i < 60; i++) wr(32'h0100_0000 + 32'(i));
    chk(dma_req === 1'b1 && level === 7'd60, "R9", 32'(level), 60);
    wr(32'h0200_0000);
    chk(dma_req === 1'b0, "R9", 32'(dma_req), 0);
    for (int i = 0; i < 3; i++) wr(32'h0300_0000 + 32'(i));
    chk(fifo_full === 1'b1 && level === 7'd64, "R3", 32'(level), 64);
    chk(overflow === 1'b0, "R3", 32'(overflow), 0);
    wr(32'hBAD0_BAD0);
    chk(level === 7'd64, "R3", 32'(level), 64);
    chk(overflow === 1'b1, "R3", 32'(overflow), 1);
    chk(smp_data === 32'h0100_0000, "R3", smp_data, 32'h0100_0000);
    dctl_we = 1'b1; dctl_dma_en = 1'b0;
    tick();
    dctl_we = 1'b0;
    chk(dma_req === 1'b0, "R9", 32'(dma_req), 0);
  endtask

  task automatic t_flush;
    fctl_we = 1'b1; fctl_flush = 1'b1;
    tick();
    fctl_we = 1'b0; fctl_flush = 1'b0;
    chk(flush_busy === 1'b1, "R4", 32'(flush_busy), 1);
    chk(smp_valid === 1'b0, "R4", 32'(smp_valid), 0);
    wr(32'h7777_7777);
    chk(flush_busy === 1'b0, "R4", 32'(flush_busy), 0);
    chk(fifo_empty === 1'b1 && level === 7'd0, "R4", 32'(level), 0);
    chk(overflow === 1'b1, "R3", 32'(overflow), 1);
    wr(32'h8888_8888);
    pop_expect(32'h8888_8888, "R4");
  endtask

  task automatic t_counter;
    cnt_we = 1'b1; cnt_wdata = 32'hFFFF_FFFE;
    tick();
    cnt_we = 1'b0;
    exp_cnt = 32'hFFFF_FFFE;
    chk(tx_count === exp_cnt, "R7", tx_count, exp_cnt);
    wr(32'h0000_00A1); wr(32'h0000_00A2);
    pop_expect(32'h0000_00A1, "R8");
    chk(tx_count === 32'hFFFF_FFFF, "R8", tx_count, 32'hFFFF_FFFF);
    pop_expect(32'h0000_00A2, "R8");
    chk(tx_count === 32'd0, "R8", tx_count, 0);
    wr(32'h0000_00A3);
    cnt_we = 1'b1; cnt_wdata = 32'h10; smp_ready = 1'b1;
    tick();
    cnt_we = 1'b0; smp_ready = 1'b0;
    chk(tx_count === 32'h10, "R7", tx_count, 32'h10);
    chk(fifo_empty === 1'b1, "R7", 32'(fifo_empty), 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    tick();
    t_reset();
    t_order();
    t_backpressure();
    t_mode();
    t_rdzero();
    t_dma_full();
    t_flush();
    t_counter();
    done = 1'b1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 100000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected done", cyc);
    end
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule